// File: doc/BRIEF.md
# Four-Lane Long-Instruction Execute Cluster

This block is the execute stage of a four-issue long-instruction-word pipeline. It takes the already decoded contents of one instruction word: four operation slots, each with two register operands, a raw 14-bit immediate and its control fields. Each slot is worked by its own 32-bit ALU lane, and the four results are captured together into the execute-to-memory pipeline register. The immediate of every slot is sign- or zero-extended on every cycle, whether the slot uses it or not.

A slot selects its operation in one of two ways. A register-register slot takes the operation from its 8-bit function field and applies it to both register operands. A register-immediate slot takes it from its 5-bit operation field and applies it to the first register operand and the extended immediate. When the word carries a load or store, lane 0 ignores both fields and computes the effective address. Lanes 1 to 3 are idle for that word and produce a zero result with their write flag cleared. Each lane's destination index and write flag are carried to the pipeline register next to its result.

Top module: `vx_exec_cluster`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: A lane's 14-bit immediate is zero-extended when its `lane_imm_uns` bit is 1. It is sign-extended from bit 13 when that bit is 0.
- R3: With `lane_use_imm`=0, the 8-bit function field selects the operation on rs and rt: 0x20 add, 0x22 sub (rs-rt), 0x24 and, 0x25 or, 0x26 xor, 0x27 nor.
- R4: With `lane_use_imm`=1, the 5-bit operation field selects the operation on rs and the extended immediate: 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 nor, 7 set-less-than signed, 8 set-less-than unsigned, 9 shift left logical, 10 shift right logical, 11 shift right arithmetic.
- R5: Shift functions 0x00 (left logical), 0x02 (right logical) and 0x03 (right arithmetic) shift rs by the low 5 bits of the second operand. Bits above those 5 are ignored, and an arithmetic right shift fills with the sign bit of rs.
- R6: Function 0x2A (signed) and 0x2B (unsigned), like operation codes 7 and 8, give 1 when rs is less than the second operand and 0 otherwise.
- R7: Any function or operation code not listed in R3 to R6 gives a result of zero.
- R8: When `mem_load` or `mem_store` is 1, lane 0 yields rs + extended immediate, whatever its function, operation and immediate-select fields hold. Its write flag passes through unchanged.
- R9: When `mem_load` or `mem_store` is 1, lanes 1 to 3 yield zero with their write flag 0.
- R10: Every lane's destination index, every write flag outside a memory word, and both memory flags appear unchanged in the pipeline register.
- R11: All four lane results of a word appear together one clock after the word is presented. A new word is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_load | input | 1 | Word holds a load |
| mem_store | input | 1 | Word holds a store |
| lane_rs | input | 128 | First operand per lane, lane i at [32i+31:32i] |
| lane_rt | input | 128 | Second register operand per lane |
| lane_imm | input | 56 | Raw 14-bit immediate per lane |
| lane_imm_uns | input | 4 | Per-lane zero-extend select |
| lane_use_imm | input | 4 | Per-lane immediate form select |
| lane_opc | input | 20 | 5-bit operation field per lane |
| lane_fn | input | 32 | 8-bit function field per lane |
| lane_dst | input | 24 | 6-bit destination index per lane |
| lane_wr | input | 4 | Per-lane register write flag |
| xm_result | output | 128 | Registered lane results |
| xm_dst | output | 24 | Registered destination indices |
| xm_wr | output | 4 | Registered write flags |
| xm_load | output | 1 | Registered load flag |
| xm_store | output | 1 | Registered store flag |

## Verification
The bench builds the block at its default parameters: four lanes of 32 bits, 14-bit immediates and 6-bit register indices. With four lanes, a single word can carry four different operations, so cross-lane slicing mistakes and same-cycle capture show up in one check. With a 14-bit immediate and a 32-bit word, the extension boundary at bit 13 can be tested directly. A 5-bit shift field narrower than the operand lets the bench put junk above the shift amount and confirm it is dropped.

// File: rtl/vx_exec_pkg.sv
package vx_exec_pkg;

   typedef enum logic [3:0] {
      OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
      OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA
   } alu_op_e;

   // register-register function field values
   localparam logic [7:0] FN_SLL  = 8'h00;
   localparam logic [7:0] FN_SRL  = 8'h02;
   localparam logic [7:0] FN_SRA  = 8'h03;
   localparam logic [7:0] FN_ADD  = 8'h20;
   localparam logic [7:0] FN_SUB  = 8'h22;
   localparam logic [7:0] FN_AND  = 8'h24;
   localparam logic [7:0] FN_OR   = 8'h25;
   localparam logic [7:0] FN_XOR  = 8'h26;
   localparam logic [7:0] FN_NOR  = 8'h27;
   localparam logic [7:0] FN_SLT  = 8'h2A;
   localparam logic [7:0] FN_SLTU = 8'h2B;

   // register-immediate operation field values
   localparam logic [4:0] OC_ADD  = 5'd1;
   localparam logic [4:0] OC_SUB  = 5'd2;
   localparam logic [4:0] OC_AND  = 5'd3;
   localparam logic [4:0] OC_OR   = 5'd4;
   localparam logic [4:0] OC_XOR  = 5'd5;
   localparam logic [4:0] OC_NOR  = 5'd6;
   localparam logic [4:0] OC_SLT  = 5'd7;
   localparam logic [4:0] OC_SLTU = 5'd8;
   localparam logic [4:0] OC_SLL  = 5'd9;
   localparam logic [4:0] OC_SRL  = 5'd10;
   localparam logic [4:0] OC_SRA  = 5'd11;

endpackage

// File: rtl/vx_imm_ext.sv
module vx_imm_ext #(
   parameter int IMM_W = 14,
   parameter int DW    = 32
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             uns,
   output logic [DW-1:0]    ext
);
   localparam int PAD_W = DW - IMM_W;

   if (IMM_W > DW) begin : g_bad_width
      $error("vx_imm_ext: immediate wider than data path");
   end

   if (PAD_W == 0) begin : g_flat
      assign ext = imm;
   end else begin : g_pad
      logic fill;
      assign fill = imm[IMM_W-1] & ~uns;
      assign ext  = {{PAD_W{fill}}, imm};
   end
endmodule

// File: rtl/vx_op_decode.sv
module vx_op_decode
   import vx_exec_pkg::*;
#(
   parameter int FN_W  = 8,
   parameter int OPC_W = 5
) (
   input  logic             use_imm,
   input  logic [FN_W-1:0]  fn,
   input  logic [OPC_W-1:0] opc,
   output alu_op_e          op
);
   if (FN_W < 6) begin : g_bad_fn
      $error("vx_op_decode: function field too narrow");
   end
   if (OPC_W < 4) begin : g_bad_opc
      $error("vx_op_decode: operation field too narrow");
   end

   alu_op_e rr_op;
   alu_op_e ri_op;

   always_comb begin
      case (fn)
         FN_W'(FN_ADD):  rr_op = OP_ADD;
         FN_W'(FN_SUB):  rr_op = OP_SUB;
         FN_W'(FN_AND):  rr_op = OP_AND;
         FN_W'(FN_OR):   rr_op = OP_OR;
         FN_W'(FN_XOR):  rr_op = OP_XOR;
         FN_W'(FN_NOR):  rr_op = OP_NOR;
         FN_W'(FN_SLT):  rr_op = OP_SLT;
         FN_W'(FN_SLTU): rr_op = OP_SLTU;
         FN_W'(FN_SLL):  rr_op = OP_SLL;
         FN_W'(FN_SRL):  rr_op = OP_SRL;
         FN_W'(FN_SRA):  rr_op = OP_SRA;
         default:        rr_op = OP_NONE;
      endcase
   end

   always_comb begin
      case (opc)
         OPC_W'(OC_ADD):  ri_op = OP_ADD;
         OPC_W'(OC_SUB):  ri_op = OP_SUB;
         OPC_W'(OC_AND):  ri_op = OP_AND;
         OPC_W'(OC_OR):   ri_op = OP_OR;
         OPC_W'(OC_XOR):  ri_op = OP_XOR;
         OPC_W'(OC_NOR):  ri_op = OP_NOR;
         OPC_W'(OC_SLT):  ri_op = OP_SLT;
         OPC_W'(OC_SLTU): ri_op = OP_SLTU;
         OPC_W'(OC_SLL):  ri_op = OP_SLL;
         OPC_W'(OC_SRL):  ri_op = OP_SRL;
         OPC_W'(OC_SRA):  ri_op = OP_SRA;
         default:         ri_op = OP_NONE;
      endcase
   end

   assign op = use_imm ? ri_op : rr_op;
endmodule

// File: rtl/vx_lane_alu.sv
module vx_lane_alu
   import vx_exec_pkg::*;
#(
   parameter int DW = 32
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   localparam int SH_W = $clog2(DW);

   if (DW < 8 || (1 << SH_W) != DW) begin : g_bad_dw
      $error("vx_lane_alu: data width must be a power of two of at least 8");
   end

   logic [SH_W-1:0] shamt;
   logic            lt_s;
   logic            lt_u;

   assign shamt = b[SH_W-1:0];
   assign lt_s  = $signed(a) < $signed(b);
   assign lt_u  = a < b;

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOR:  y = ~(a | b);
         OP_SLT:  y = DW'(lt_s);
         OP_SLTU: y = DW'(lt_u);
         OP_SLL:  y = a << shamt;
         OP_SRL:  y = a >> shamt;
         OP_SRA:  y = DW'($signed(a) >>> shamt);
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/vx_exec_cluster.sv
module vx_exec_cluster
   import vx_exec_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int DW     = 32,
   parameter int IMM_W  = 14,
   parameter int OPC_W  = 5,
   parameter int FN_W   = 8,
   parameter int RIDX_W = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mem_load,
   input  logic                    mem_store,
   input  logic [LANES*DW-1:0]     lane_rs,
   input  logic [LANES*DW-1:0]     lane_rt,
   input  logic [LANES*IMM_W-1:0]  lane_imm,
   input  logic [LANES-1:0]        lane_imm_uns,
   input  logic [LANES-1:0]        lane_use_imm,
   input  logic [LANES*OPC_W-1:0]  lane_opc,
   input  logic [LANES*FN_W-1:0]   lane_fn,
   input  logic [LANES*RIDX_W-1:0] lane_dst,
   input  logic [LANES-1:0]        lane_wr,
   output logic [LANES*DW-1:0]     xm_result,
   output logic [LANES*RIDX_W-1:0] xm_dst,
   output logic [LANES-1:0]        xm_wr,
   output logic                    xm_load,
   output logic                    xm_store
);
   localparam int AGU_LANE = 0;

   if (LANES < 1) begin : g_bad_lanes
      $error("vx_exec_cluster: at least one lane required");
   end
   if (RIDX_W < 1) begin : g_bad_ridx
      $error("vx_exec_cluster: register index width must be positive");
   end

   logic                    is_mem;
   logic [LANES*DW-1:0]     res_d;
   logic [LANES-1:0]        wr_d;

   assign is_mem = mem_load | mem_store;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [DW-1:0] rs;
      logic [DW-1:0] rt;
      logic [DW-1:0] imm_ext;
      logic [DW-1:0] opnd_b;
      logic [DW-1:0] y;
      alu_op_e       dec_op;
      alu_op_e       op;

      assign rs = lane_rs[g*DW +: DW];
      assign rt = lane_rt[g*DW +: DW];

      vx_imm_ext #(.IMM_W(IMM_W), .DW(DW)) u_ext (
         .imm (lane_imm[g*IMM_W +: IMM_W]),
         .uns (lane_imm_uns[g]),
         .ext (imm_ext)
      );

      vx_op_decode #(.FN_W(FN_W), .OPC_W(OPC_W)) u_dec (
         .use_imm (lane_use_imm[g]),
         .fn      (lane_fn[g*FN_W +: FN_W]),
         .opc     (lane_opc[g*OPC_W +: OPC_W]),
         .op      (dec_op)
      );

      if (g == AGU_LANE) begin : g_agu
         // address lane: forced add with immediate on memory words
         assign op     = is_mem ? OP_ADD : dec_op;
         assign opnd_b = (is_mem || lane_use_imm[g]) ? imm_ext : rt;
         assign res_d[g*DW +: DW] = y;
         assign wr_d[g]           = lane_wr[g];
      end else begin : g_plain
         assign op     = dec_op;
         assign opnd_b = lane_use_imm[g] ? imm_ext : rt;
         assign res_d[g*DW +: DW] = is_mem ? '0 : y;
         assign wr_d[g]           = lane_wr[g] & ~is_mem;
      end

      vx_lane_alu #(.DW(DW)) u_alu (
         .op (op),
         .a  (rs),
         .b  (opnd_b),
         .y  (y)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xm_result <= '0;
         xm_dst    <= '0;
         xm_wr     <= '0;
         xm_load   <= 1'b0;
         xm_store  <= 1'b0;
      end else begin
         xm_result <= res_d;
         xm_dst    <= lane_dst;
         xm_wr     <= wr_d;
         xm_load   <= mem_load;
         xm_store  <= mem_store;
      end
   end
endmodule

// File: rtl/vx_exec_cluster_chk.sv
module vx_exec_cluster_chk #(
   parameter int LANES  = 4,
   parameter int DW     = 32,
   parameter int IMM_W  = 14,
   parameter int RIDX_W = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mem_load,
   input logic                    mem_store,
   input logic [LANES*DW-1:0]     lane_rs,
   input logic [LANES*IMM_W-1:0]  lane_imm,
   input logic [LANES-1:0]        lane_imm_uns,
   input logic [LANES*RIDX_W-1:0] lane_dst,
   input logic [LANES-1:0]        lane_wr,
   input logic [LANES*DW-1:0]     xm_result,
   input logic [LANES*RIDX_W-1:0] xm_dst,
   input logic [LANES-1:0]        xm_wr,
   input logic                    xm_load,
   input logic                    xm_store
);
   logic          mem_word;
   logic [DW-1:0] addr_exp;
   logic [DW-1:0] imm0;

   assign mem_word = mem_load | mem_store;
   assign imm0 = lane_imm_uns[0] ? DW'(lane_imm[IMM_W-1:0])
                                 : DW'($signed(lane_imm[IMM_W-1:0]));
   assign addr_exp = lane_rs[DW-1:0] + imm0;

   AST_AGU_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_word |=> xm_result[DW-1:0] == $past(addr_exp)); // R8

   if (LANES > 1) begin : g_idle
      AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         mem_word |=> (xm_result[LANES*DW-1:DW] == '0) && (xm_wr[LANES-1:1] == '0)); // R9
   end

   AST_DST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> xm_dst == $past(lane_dst)); // R10

   AST_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_word |=> xm_wr == $past(lane_wr)); // R10

   AST_MEMFLAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (xm_load == $past(mem_load)) && (xm_store == $past(mem_store))); // R10

   AST_AGU_WR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_word |=> xm_wr[0] == $past(lane_wr[0])); // R8
endmodule

bind vx_exec_cluster vx_exec_cluster_chk #(
   .LANES(LANES), .DW(DW), .IMM_W(IMM_W), .RIDX_W(RIDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_load(mem_load), .mem_store(mem_store),
   .lane_rs(lane_rs), .lane_imm(lane_imm), .lane_imm_uns(lane_imm_uns),
   .lane_dst(lane_dst), .lane_wr(lane_wr), .xm_result(xm_result),
   .xm_dst(xm_dst), .xm_wr(xm_wr), .xm_load(xm_load), .xm_store(xm_store)
);

// File: tb/vx_exec_cluster_bench.sv
module vx_exec_cluster_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 4;
   localparam int DW     = 32;
   localparam int IMM_W  = 14;
   localparam int OPC_W  = 5;
   localparam int FN_W   = 8;
   localparam int RIDX_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mem_load = 1'b0, mem_store = 1'b0;
   logic [LANES*DW-1:0]     rs_v = '0, rt_v = '0;
   logic [LANES*IMM_W-1:0]  imm_v = '0;
   logic [LANES-1:0]        uns_v = '0, isel_v = '0, wr_v = '0;
   logic [LANES*OPC_W-1:0]  opc_v = '0;
   logic [LANES*FN_W-1:0]   fn_v = '0;
   logic [LANES*RIDX_W-1:0] dst_v = '0;
   logic [LANES*DW-1:0]     xm_result;
   logic [LANES*RIDX_W-1:0] xm_dst;
   logic [LANES-1:0]        xm_wr;
   logic                    xm_load, xm_store;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vx_exec_cluster u_vx_exec_cluster (
      .clk(clk), .rst_n(rst_n), .mem_load(mem_load), .mem_store(mem_store),
      .lane_rs(rs_v), .lane_rt(rt_v), .lane_imm(imm_v), .lane_imm_uns(uns_v),
      .lane_use_imm(isel_v), .lane_opc(opc_v), .lane_fn(fn_v), .lane_dst(dst_v),
      .lane_wr(wr_v), .xm_result(xm_result), .xm_dst(xm_dst), .xm_wr(xm_wr),
      .xm_load(xm_load), .xm_store(xm_store)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ext(logic [13:0] imm, logic uns);
      return uns ? {18'd0, imm} : {{18{imm[13]}}, imm};
   endfunction

   function automatic logic [31:0] ref_op(int k, logic [31:0] a, logic [31:0] b);
      // k: 1 add 2 sub 3 and 4 or 5 xor 6 nor 7 slt 8 sltu 9 sll 10 srl 11 sra
      case (k)
         1: return a + b;
         2: return a - b;
         3: return a & b;
         4: return a | b;
         5: return a ^ b;
         6: return ~(a | b);
         7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         8: return (a < b) ? 32'd1 : 32'd0;
         9: return a << b[4:0];
         10: return a >> b[4:0];
         11: return 32'($signed(a) >>> b[4:0]);
         default: return 32'd0;
      endcase
   endfunction

   function automatic int fn2k(logic [7:0] f);
      case (f)
         8'h20: return 1; 8'h22: return 2; 8'h24: return 3; 8'h25: return 4;
         8'h26: return 5; 8'h27: return 6; 8'h2A: return 7; 8'h2B: return 8;
         8'h00: return 9; 8'h02: return 10; 8'h03: return 11;
         default: return 0;
      endcase
   endfunction

   function automatic int oc2k(logic [4:0] o);
      return (o >= 5'd1 && o <= 5'd11) ? int'(o) : 0;
   endfunction

   task automatic set_rr(int l, logic [31:0] a, logic [31:0] b, logic [7:0] f);
      rs_v[l*DW +: DW] = a; rt_v[l*DW +: DW] = b;
      fn_v[l*FN_W +: FN_W] = f; isel_v[l] = 1'b0;
      opc_v[l*OPC_W +: OPC_W] = 5'd31;
   endtask

   task automatic set_ri(int l, logic [31:0] a, logic [13:0] imm, logic uns, logic [4:0] o);
      rs_v[l*DW +: DW] = a; imm_v[l*IMM_W +: IMM_W] = imm; uns_v[l] = uns;
      opc_v[l*OPC_W +: OPC_W] = o; isel_v[l] = 1'b1;
      fn_v[l*FN_W +: FN_W] = 8'hFF;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [31:0] res(int l);
      return xm_result[l*DW +: DW];
   endfunction

   task automatic t_reset();
      chk("R1 result", xm_result[31:0] | xm_result[63:32] | xm_result[95:64] | xm_result[127:96], 32'd0);
      chk("R1 dst", 32'(xm_dst), 32'd0);
      chk("R1 wr/flags", {27'd0, xm_wr, xm_load | xm_store}, 32'd0);
   endtask

   task automatic t_rr_logic();
      logic [7:0] f [4] = '{8'h20, 8'h22, 8'h24, 8'h27};
      logic [7:0] g [4] = '{8'h25, 8'h26, 8'h22, 8'h20};
      logic [31:0] a [4] = '{32'h7FFF_FFFF, 32'h0000_0005, 32'hF0F0_1234, 32'h00FF_00FF};
      logic [31:0] b [4] = '{32'h0000_0001, 32'h0000_0009, 32'h0FF0_FFFF, 32'h0F0F_0000};
      for (int l = 0; l < LANES; l++) set_rr(l, a[l], b[l], f[l]);
      step();
      for (int l = 0; l < LANES; l++) chk("R3/R11 rr set A", res(l), ref_op(fn2k(f[l]), a[l], b[l]));
      for (int l = 0; l < LANES; l++) set_rr(l, b[l], a[l], g[l]);
      step();
      for (int l = 0; l < LANES; l++) chk("R3/R11 rr set B", res(l), ref_op(fn2k(g[l]), b[l], a[l]));
   endtask

   task automatic t_ri_ext();
      set_ri(0, 32'h0000_1000, 14'h3FFF, 1'b0, 5'd1);
      set_ri(1, 32'h0000_1000, 14'h3FFF, 1'b1, 5'd1);
      set_ri(2, 32'hFFFF_0000, 14'h2000, 1'b0, 5'd4);
      set_ri(3, 32'hFFFF_0000, 14'h2000, 1'b1, 5'd4);
      step();
      chk("R2 signed ext add", res(0), 32'h0000_0FFF);
      chk("R2 unsigned ext add", res(1), 32'h0000_4FFF);
      chk("R2 signed ext or", res(2), 32'hFFFF_E000);
      chk("R2 unsigned ext or", res(3), 32'hFFFF_2000);
      for (int o = 1; o <= 11; o++) begin
         for (int l = 0; l < LANES; l++)
            set_ri(l, 32'h8000_00F3 ^ (l * 32'h1111), 14'(o * 5 + l * 1000 + 3), l[0], 5'(o));
         step();
         for (int l = 0; l < LANES; l++)
            chk("R4 ri op", res(l), ref_op(o, 32'h8000_00F3 ^ (l * 32'h1111),
                ext(14'(o * 5 + l * 1000 + 3), l[0])));
      end
   endtask

   task automatic t_shift_slt();
      set_rr(0, 32'h8000_0010, 32'hFFFF_FFE3, 8'h00);
      set_rr(1, 32'h8000_0010, 32'h0000_0023, 8'h02);
      set_rr(2, 32'h8000_0010, 32'h1234_5664, 8'h03);
      set_rr(3, 32'h4000_0000, 32'h0000_003F, 8'h03);
      step();
      chk("R5 sll high bits ignored", res(0), 32'h0000_0080);
      chk("R5 srl", res(1), 32'h1000_0002);
      chk("R5 sra negative fill", res(2), 32'hF800_0001);
      chk("R5 sra positive by 31", res(3), 32'h0000_0000);
      set_rr(0, 32'hFFFF_FFFF, 32'h0000_0001, 8'h2A);
      set_rr(1, 32'hFFFF_FFFF, 32'h0000_0001, 8'h2B);
      set_ri(2, 32'hFFFF_FFFE, 14'h3FFF, 1'b0, 5'd7);
      set_ri(3, 32'h0000_0005, 14'h3FFF, 1'b0, 5'd8);
      step();
      chk("R6 slt signed", res(0), 32'd1);
      chk("R6 sltu", res(1), 32'd0);
      chk("R6 slt imm", res(2), 32'd1);
      chk("R6 sltu imm", res(3), 32'd1);
   endtask

   task automatic t_undef();
      set_rr(0, 32'hDEAD_BEEF, 32'h1234_5678, 8'hFF);
      set_rr(1, 32'hDEAD_BEEF, 32'h1234_5678, 8'h21);
      set_ri(2, 32'hDEAD_BEEF, 14'h0123, 1'b0, 5'd0);
      set_ri(3, 32'hDEAD_BEEF, 14'h0123, 1'b0, 5'd12);
      step();
      for (int l = 0; l < LANES; l++) chk("R7 undefined code", res(l), 32'd0);
   endtask

   task automatic t_mem();
      wr_v = 4'b1111;
      set_rr(0, 32'h0000_1000, 32'h5555_5555, 8'h24);
      imm_v[13:0] = 14'h3FF0; uns_v[0] = 1'b0;
      for (int l = 1; l < LANES; l++) set_rr(l, 32'h0000_0003, 32'h0000_0004, 8'h20);
      mem_load = 1'b1;
      step();
      chk("R8 load address", res(0), 32'h0000_0FF0);
      chk("R8 load lane0 wr", 32'(xm_wr[0]), 32'd1);
      for (int l = 1; l < LANES; l++) chk("R9 idle result", res(l), 32'd0);
      chk("R9 idle wr", 32'(xm_wr[3:1]), 32'd0);
      chk("R10 load flag", {30'd0, xm_load, xm_store}, 32'd2);
      mem_load = 1'b0; mem_store = 1'b1; wr_v = 4'b1110;
      set_ri(0, 32'h0000_2000, 14'h0010, 1'b1, 5'd2);
      step();
      chk("R8 store address", res(0), 32'h0000_2010);
      chk("R9 store idle wr", 32'(xm_wr), 32'd0);
      chk("R10 store flag", {30'd0, xm_load, xm_store}, 32'd1);
      mem_store = 1'b0;
      step();
      chk("R9 lanes resume", res(1), 32'd7);
   endtask

   task automatic t_pass();
      dst_v = {6'd63, 6'd0, 6'd21, 6'd42};
      wr_v = 4'b0101;
      step();
      chk("R10 dst", 32'(xm_dst), 32'({6'd63, 6'd0, 6'd21, 6'd42}));
      chk("R10 wr", 32'(xm_wr), 32'd5);
      dst_v = {6'd1, 6'd2, 6'd3, 6'd4};
      wr_v = 4'b1010;
      step();
      chk("R10 dst next", 32'(xm_dst), 32'({6'd1, 6'd2, 6'd3, 6'd4}));
      chk("R10 wr next", 32'(xm_wr), 32'd10);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_rr_logic();
      t_ri_ext();
      t_shift_slt();
      t_undef();
      t_mem();
      t_pass();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule